// File: doc/BRIEF.md
# SMBus Clock Timeout and Stretch Monitor

A passive observer for the clock and data lines of an SMBus or PMBus target port. It looks at the bus through a two-flop synchronizer and never drives it. It does three things. It catches a clock held low without a break for too long; it then raises a sticky flag and sends a single-cycle reset pulse to the target's interface logic. When enabled, it catches a clock held high for too long in the middle of a message. It also keeps a running estimate of how much the target has stretched the clock during the current message.

The stretch estimate works from the target's byte-completion strobe. Each strobe captures a free-running timestamp. From the second byte of a message on, the monitor takes the gap since the previous byte and subtracts an assumed nominal byte time. Negative results count as zero. The remainder is added to a per-message sum, and a sticky overrun flag is raised once the sum passes a fixed limit.

The time limits are parameters counted in system clock cycles. Defaults correspond to 35 ms for the low timeout and 25 ms for the cumulative limit at 125 MHz. Software reads the flags and clears each one by writing a one to its bit.

Top module: `smb_clk_tmon`

## Requirements
- R1: After SCL has been low at the synchronizer output for LOW_TO_CYC consecutive cycles, `if_reset_o` pulses high for exactly one cycle, and `low_to_o` is set on the following cycle. Each continuous low period produces at most one pulse.
- R2: The low counter restarts whenever synchronized SCL is high. Low periods shorter than LOW_TO_CYC never set `low_to_o` or pulse `if_reset_o`.
- R3: While `high_to_en_i` is 1 and a message is active, SCL held high for `high_limit_i` consecutive cycles (limit ≥ 1) sets `high_to_o` one cycle after the counter reaches the limit. With the enable at 0, or outside a message, the flag is not set.
- R4: Byte timestamps come from a free-running TS_W-bit counter that starts at 0 on reset. Gaps are computed modulo 2^TS_W, so a gap that spans a counter wrap is measured correctly.
- R5: For each accepted byte after the first of a message, the stretch is the gap since the previous byte minus `nom_byte_i`, clamped at 0. This is added to `stretch_sum_o`, which saturates at 2^TS_W−1. A start clears the sum, and the first byte after a start adds nothing.
- R6: `cum_ovr_o` is set in the cycle the new sum is registered, whenever that sum exceeds CUM_LIM_CYC.
- R7: `byte_kind_o` gives the class of the last accepted byte in the cycle after its strobe. The codes are 0 = address (1st byte), 1 = command (2nd byte) and 2 = data (later bytes). At a stop ending a message of three or more bytes, it changes to 3 = PEC.
- R8: A start is SDA falling while SCL is high, and it makes `msg_active_o` 1. A stop is SDA rising while SCL is high, and it makes `msg_active_o` 0. Both are seen through the two-flop synchronizer, so `msg_active_o` changes 3 cycles after the line change is applied. Byte strobes while no message is active have no effect.
- R9: `low_to_o`, `high_to_o` and `cum_ovr_o` are 0 after reset and stay set until cleared through `clr_i`: bit 0 clears low, bit 1 clears high, bit 2 clears cumulative. A set in the same cycle wins over a clear.
- R10: An `if_reset_o` pulse aborts the current message. `msg_active_o` drops the next cycle and later strobes are ignored until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| byte_done_i | input | 1 | Byte-completion strobe from the target shifter |
| high_to_en_i | input | 1 | Enables the clock-high timeout |
| high_limit_i | input | HIGH_W | Clock-high threshold in cycles |
| nom_byte_i | input | TS_W | Assumed nominal byte time in cycles |
| clr_i | input | 3 | Write-one-to-clear for the low, high and cumulative flags |
| if_reset_o | output | 1 | One-cycle reset pulse to the interface logic |
| low_to_o | output | 1 | Sticky clock-low timeout flag |
| high_to_o | output | 1 | Sticky clock-high timeout flag |
| cum_ovr_o | output | 1 | Sticky cumulative stretch overrun flag |
| stretch_sum_o | output | TS_W | Stretch estimate for the current or last message |
| byte_kind_o | output | 2 | Class of the last byte |
| msg_active_o | output | 1 | A message is in progress |

## Verification
A miscounted low or high counter shows up as `if_reset_o`, `low_to_o` or `high_to_o` moving one or more cycles away from the edge the bench predicts, and it is caught in that same cycle. A corrupt timestamp or accumulator shows as a wrong `stretch_sum_o` in the cycle after the byte strobe. A missed start or stop shows at once as a wrong `msg_active_o`, and later as a sum or byte class that disagrees with the model. Since every output is compared on every clock, no error survives more than one cycle beyond the first port it reaches.

// File: rtl/smb_tmon_pkg.sv
package smb_tmon_pkg;
  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_DATA = 2'd2,
    KIND_PEC  = 2'd3
  } byte_kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sda_d <= 1'b1;
    else         sda_d <= sda_ff[STAGES-1];

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign start_o = scl_o &&  sda_d && !sda_o;
  assign stop_o  = scl_o && !sda_d &&  sda_o;

  assert_start_stop_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/smb_level_timer.sv
// Counts consecutive armed cycles; one registered pulse when the limit is reached.
module smb_level_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= arm_i && (cnt_q == limit_i - CNT_W'(1));
      if (!arm_i)                cnt_q <= '0;
      else if (cnt_q != limit_i) cnt_q <= cnt_q + CNT_W'(1);
    end

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
  assert_pulse_needs_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(arm_i));
endmodule

// File: rtl/smb_stretch_acc.sv
module smb_stretch_acc
  import smb_tmon_pkg::*;
#(
  parameter int TS_W    = 24,
  parameter int CUM_LIM = 3_125_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            abort_i,
  input  logic            byte_i,
  input  logic [TS_W-1:0] nom_i,
  input  logic            clr_cum_i,
  output logic [TS_W-1:0] sum_o,
  output logic            cum_ovr_o,
  output byte_kind_e      kind_o,
  output logic            active_o
);
  localparam logic [TS_W-1:0] CUM_LIM_V = TS_W'(CUM_LIM);
  localparam logic [TS_W:0]   SUM_MAX   = {1'b0, {TS_W{1'b1}}};

  logic [TS_W-1:0] tmr_q, prev_q, gap, stretch;
  logic [TS_W:0]   sum_wide;
  logic [TS_W-1:0] sum_next;
  logic            have_prev_q;
  logic [1:0]      nb_q;
  logic            take_byte, add_stretch, cum_set;

  assign gap         = tmr_q - prev_q;  // modulo 2^TS_W
  assign stretch     = (gap > nom_i) ? gap - nom_i : '0;
  assign sum_wide    = {1'b0, sum_o} + {1'b0, stretch};
  assign sum_next    = (sum_wide > SUM_MAX) ? {TS_W{1'b1}} : sum_wide[TS_W-1:0];
  assign take_byte   = byte_i && active_o && !abort_i && !start_i && !stop_i;
  assign add_stretch = take_byte && have_prev_q;
  assign cum_set     = add_stretch && (sum_next > CUM_LIM_V);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= tmr_q + TS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sum_o       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      nb_q        <= '0;
      active_o    <= 1'b0;
      kind_o      <= KIND_ADDR;
    end else if (abort_i) begin
      active_o    <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (start_i) begin
      active_o    <= 1'b1;
      sum_o       <= '0;
      have_prev_q <= 1'b0;
      nb_q        <= '0;
    end else if (stop_i && active_o) begin
      active_o <= 1'b0;
      if (nb_q == 2'd3) kind_o <= KIND_PEC;
    end else if (take_byte) begin
      unique case (nb_q)
        2'd0:    kind_o <= KIND_ADDR;
        2'd1:    kind_o <= KIND_CMD;
        default: kind_o <= KIND_DATA;
      endcase
      if (nb_q != 2'd3) nb_q <= nb_q + 2'd1;
      if (have_prev_q)  sum_o <= sum_next;
      prev_q      <= tmr_q;
      have_prev_q <= 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cum_ovr_o <= 1'b0;
    else if (cum_set)   cum_ovr_o <= 1'b1;
    else if (clr_cum_i) cum_ovr_o <= 1'b0;

  assert_start_clears_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> (sum_o == '0 && active_o));
  assert_idle_byte_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> $stable(sum_o));
  assert_sum_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i) |=> (sum_o >= $past(sum_o)));
  assert_cum_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cum_ovr_o && !clr_cum_i) |=> cum_ovr_o);
  assert_abort_idles_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !active_o);
endmodule

// File: rtl/smb_clk_tmon.sv
module smb_clk_tmon
  import smb_tmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TS_W        = 24,
  parameter int HIGH_W      = 24,
  parameter int LOW_TO_CYC  = 4_375_000,
  parameter int CUM_LIM_CYC = 3_125_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              byte_done_i,
  input  logic              high_to_en_i,
  input  logic [HIGH_W-1:0] high_limit_i,
  input  logic [TS_W-1:0]   nom_byte_i,
  input  logic [2:0]        clr_i,
  output logic              if_reset_o,
  output logic              low_to_o,
  output logic              high_to_o,
  output logic              cum_ovr_o,
  output logic [TS_W-1:0]   stretch_sum_o,
  output logic [1:0]        byte_kind_o,
  output logic              msg_active_o
);
  localparam int LOW_W = $clog2(LOW_TO_CYC + 1);

  logic       scl_s, sda_s, start_s, stop_s;
  logic       low_hit, high_hit;
  byte_kind_e kind;

  smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_s), .stop_o(stop_s)
  );

  smb_level_timer #(.CNT_W(LOW_W)) i_low_tmr (
    .clk_i, .rst_ni,
    .arm_i(!scl_s), .limit_i(LOW_W'(LOW_TO_CYC)), .hit_o(low_hit)
  );

  smb_level_timer #(.CNT_W(HIGH_W)) i_high_tmr (
    .clk_i, .rst_ni,
    .arm_i(scl_s && msg_active_o && high_to_en_i),
    .limit_i(high_limit_i), .hit_o(high_hit)
  );

  smb_stretch_acc #(.TS_W(TS_W), .CUM_LIM(CUM_LIM_CYC)) i_acc (
    .clk_i, .rst_ni,
    .start_i(start_s), .stop_i(stop_s), .abort_i(low_hit), .byte_i(byte_done_i),
    .nom_i(nom_byte_i), .clr_cum_i(clr_i[2]),
    .sum_o(stretch_sum_o), .cum_ovr_o, .kind_o(kind), .active_o(msg_active_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      low_to_o  <= 1'b0;
      high_to_o <= 1'b0;
    end else begin
      if (low_hit)        low_to_o  <= 1'b1;
      else if (clr_i[0])  low_to_o  <= 1'b0;
      if (high_hit)       high_to_o <= 1'b1;
      else if (clr_i[1])  high_to_o <= 1'b0;
    end

  assign if_reset_o  = low_hit;
  assign byte_kind_o = kind;

  assert_low_flag_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_to_o) |-> $past(if_reset_o));
  assert_high_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_to_o && !clr_i[1]) |=> high_to_o);
  assert_reset_only_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_reset_o |-> !$past(scl_s));
endmodule

// File: tb/test_smb_clk_tmon.sv
module test_smb_clk_tmon;
  localparam int TS_W = 10, HIGH_W = 8, LOW_TO = 40, CUM_LIM = 200;
  localparam int MASK = (1 << TS_W) - 1;
  localparam int NOM  = 20;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda = 1, bd = 0, hen = 0;
  logic [HIGH_W-1:0] hlim = 8'd30;
  logic [2:0] clr = 0;
  logic if_rst, lowf, highf, cumf, act;
  logic [TS_W-1:0] sum;
  logic [1:0] kind;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smb_clk_tmon #(.TS_W(TS_W), .HIGH_W(HIGH_W), .LOW_TO_CYC(LOW_TO), .CUM_LIM_CYC(CUM_LIM))
  i_smb_clk_tmon (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .byte_done_i(bd),
    .high_to_en_i(hen), .high_limit_i(hlim), .nom_byte_i(TS_W'(NOM)), .clr_i(clr),
    .if_reset_o(if_rst), .low_to_o(lowf), .high_to_o(highf), .cum_ovr_o(cumf),
    .stretch_sum_o(sum), .byte_kind_o(kind), .msg_active_o(act)
  );

  // reference model state
  int s1c = 1, s1d = 1, s2c = 1, s2d = 1, sdad = 1;
  int lowrun = 0, highrun = 0, lp = 0, hp = 0, mlow = 0, mhigh = 0, mcum = 0;
  int tmr = 0, prev = 0, havep = 0, nb = 0, msum = 0, mact = 0, mkind = 0;

  task automatic chk(string tag, int a, int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, a, e, $time);
    end
  endtask

  task automatic model_step();
    int start, stop, arm, gap, st;
    int o_lp = lp, o_hp = hp, o_act = mact;
    start = s2c && sdad && !s2d;
    stop  = s2c && !sdad && s2d;
    lp = (!s2c && lowrun == LOW_TO - 1);
    lowrun = s2c ? 0 : (lowrun < LOW_TO ? lowrun + 1 : lowrun);
    arm = s2c && o_act && hen;
    hp = arm && (highrun == int'(hlim) - 1);
    highrun = !arm ? 0 : (highrun != int'(hlim) ? highrun + 1 : highrun);
    if (o_lp) mlow = 1; else if (clr[0]) mlow = 0;
    if (o_hp) mhigh = 1; else if (clr[1]) mhigh = 0;
    if (o_lp) begin mact = 0; havep = 0; end
    else if (start) begin mact = 1; msum = 0; havep = 0; nb = 0; end
    else if (stop && o_act) begin mact = 0; if (nb >= 3) mkind = 3; end
    else if (bd && o_act) begin
      mkind = (nb == 0) ? 0 : (nb == 1) ? 1 : 2;
      if (nb < 3) nb++;
      if (havep) begin
        gap = (tmr - prev) & MASK;
        st = (gap > NOM) ? gap - NOM : 0;
        msum = (msum + st > MASK) ? MASK : msum + st;
        if (msum > CUM_LIM) mcum = 2;
      end
      prev = tmr; havep = 1;
    end
    if (mcum == 2) mcum = 1; else if (clr[2]) mcum = 0;
    tmr = (tmr + 1) & MASK;
    s2c = s1c; s2d = s1d; sdad = s2d; s1c = scl; s1d = sda;
  endtask

  // fix: sync shift order (sda_d takes the old s2d)
  task automatic tick();
    @(negedge clk);
    chk("R1 if_reset_o", if_rst, lp);
    chk("R9 low_to_o", lowf, mlow);
    chk("R3 high_to_o", highf, mhigh);
    chk("R6 cum_ovr_o", cumf, mcum);
    chk("R5 stretch_sum_o", int'(sum), msum);
    chk("R7 byte_kind_o", int'(kind), mkind);
    chk("R8 msg_active_o", act, mact);
    bd = 0; clr = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      model_step_wrap();
      tick();
    end
  endtask

  task automatic model_step_wrap();
    int old_s2d = s2d;
    model_step();
    sdad = old_s2d;
  endtask

  task automatic pulse_byte(int gap_after);
    bd = 1; run(gap_after);
  endtask

  task automatic start_msg(); scl = 1; sda = 0; run(4); endtask
  task automatic stop_msg();  scl = 1; sda = 1; run(4); endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R9)
    chk("R9 reset low_to_o", lowf, 0);
    chk("R9 reset cum_ovr_o", cumf, 0);
    chk("R8 reset msg_active_o", act, 0);
    rst_n = 1;
    run(5);

    // R1: continuous low
    scl = 0; run(LOW_TO + 20);
    chk("R1 low_to_o after long low", lowf, 1);
    scl = 1; run(3);
    clr = 3'b001; run(2);
    chk("R9 low_to_o cleared", lowf, 0);

    // R2: short lows
    for (int k = 0; k < 3; k++) begin scl = 0; run(LOW_TO - 5); scl = 1; run(3); end
    chk("R2 no timeout on short lows", lowf, 0);

    // R5/R7: gaps 30,25,15,50 nominal 20 -> 10+5+0+30
    start_msg();
    chk("R8 active after start", act, 1);
    pulse_byte(30); pulse_byte(25);
    chk("R7 second byte command", kind, 1);
    pulse_byte(15); pulse_byte(50); pulse_byte(5);
    chk("R5 sum of stretches", sum, 45);
    stop_msg();
    chk("R7 last byte reclassed PEC", kind, 3);
    chk("R8 idle after stop", act, 0);

    // R8: idle strobes ignored
    pulse_byte(40); pulse_byte(40); pulse_byte(3);
    chk("R8 idle strobes leave sum", sum, 45);

    // R7: two-byte message stays command
    start_msg(); pulse_byte(10); pulse_byte(3); stop_msg();
    chk("R7 short message class", kind, 1);
    chk("R5 start cleared sum", sum, 0);

    // R6: 80 + 130 > 200
    start_msg(); pulse_byte(100); pulse_byte(150); pulse_byte(3); stop_msg();
    chk("R6 overrun set", cumf, 1);
    clr = 3'b100; run(2);
    chk("R9 overrun cleared", cumf, 0);

    // R4/R5: wrap and saturation
    start_msg(); pulse_byte(1000); pulse_byte(1000); pulse_byte(1000); pulse_byte(3);
    chk("R4 saturated sum across wraps", sum, MASK);
    stop_msg(); clr = 3'b100; run(2);

    // R3: high timeout enabled / disabled
    hen = 1; start_msg(); run(50);
    chk("R3 high timeout set", highf, 1);
    stop_msg(); clr = 3'b010; run(2);
    hen = 0; start_msg(); run(50); stop_msg();
    chk("R3 disabled no flag", highf, 0);
    hen = 1; run(60);
    chk("R3 idle no flag", highf, 0);
    hen = 0;

    // R10: abort mid-message
    start_msg(); pulse_byte(30);
    scl = 0; run(LOW_TO + 10);
    chk("R10 aborted message idle", act, 0);
    scl = 1; run(3);
    pulse_byte(60); pulse_byte(3);
    chk("R10 strobes after abort ignored", sum, 0);
    clr = 3'b111; run(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule